// File: doc/BRIEF.md
# Debug Run-Control Register Unit

This unit holds the 32-bit debug control word of one processor core and turns it into the core's halt/run state. Debug software writes the word through a simple write port and reads it back continuously. Breakpoint events, external halt and run triggers, and a single-step retire strobe from the core are qualified by enable fields in the word. A qualified event parks the core in the halted state and sets the run-control bit so that software sees the halt.

The run-control bit (bit 0) is guarded: a register write moves it only when the load-enable bit (bit 1) is also 1 in the same write. Bit 1 holds no state. Reset-request and cancel-request bits give one-cycle pulses and then clear themselves. Other fields, including the unused ones, hold whatever was written.

Top module: `dbg_runctl`

## Requirements
- R1: After reset, rdata_o reads 32'h0000_0200 (only bit 9 set), halt_req_o is 0, swbp_nop_o is 1, and reset_req_o and cancel_req_o are 0.
- R2: A write changes bit 0 (halt_req_o) to wdata_i[0] on the next edge only if wdata_i[1] is 1 in that write. Otherwise bit 0 keeps its value. Bit 1 always reads 0.
- R3: A software-breakpoint pulse sets halt only when bit 5 is 1. swbp_nop_o equals the inverse of bit 5.
- R4: A hardware-breakpoint pulse on index i sets halt only when bit 6 is 1 and hwbp_loc_en_i[i] is 1 in the same cycle.
- R5: A trace-generated breakpoint pulse sets halt only when bit 8 is 1.
- R6: ext_halt_i sets halt only when bit 11 is 1. ext_run_i clears halt only when bit 10 is 1. When both are qualified in the same cycle, halt wins.
- R7: When bit 9 is 1 and ext_dbg_en_i is 0, none of the halting sources of R3 to R6 or R10 sets halt. When bit 9 is 0, ext_dbg_en_i has no effect.
- R8: A qualified halting event in the same cycle as a load-enabled write of 0 to bit 0 leaves halt at 1.
- R9: Writing 1 to bit 25 drives reset_req_o high for exactly the cycle after the write, and bit 25 reads 1 only in that cycle. Bit 30 does the same for cancel_req_o.
- R10: With bit 4 set and halt at 0, a retire_i pulse sets halt on the next edge.
- R11: All bits other than 0, 1, 25 and 30 store and read back as written. exec_mode_o is bits 3:2, step_en_o is bit 4, and step_type_o is bit 7.
- R12: Every state change is registered: a write or event in one cycle appears on the outputs after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data |
| swbp_evt_i | input | 1 | Software breakpoint detected |
| hwbp_evt_i | input | NUM_HWBP | Hardware breakpoint hits, one per comparator |
| hwbp_loc_en_i | input | NUM_HWBP | Local enable per hardware breakpoint |
| trbp_evt_i | input | 1 | Imprecise trace-generated breakpoint |
| ext_halt_i | input | 1 | External halt trigger |
| ext_run_i | input | 1 | External run trigger |
| ext_dbg_en_i | input | 1 | External debug-enable qualifier |
| retire_i | input | 1 | Core retired one instruction |
| halt_req_o | output | 1 | Halt request to the core |
| step_en_o | output | 1 | Single-step enable |
| step_type_o | output | 1 | Single-step interrupt behaviour |
| exec_mode_o | output | 2 | Execution mode |
| reset_req_o | output | 1 | One-cycle core reset request |
| cancel_req_o | output | 1 | One-cycle execution-control cancel |
| swbp_nop_o | output | 1 | Fetch treats breakpoint opcodes as no-ops |

## Verification
A halting event and a software write to the run-control bit can arrive in the same cycle. The bench sends a software breakpoint pulse in the same cycle as a load-enabled write that clears bit 0, from both the running and the halted state, and expects halt to read 1 after the edge. External halt and run triggers also collide on purpose, and halt must win. Each breakpoint source is swept over every combination of its enable, the qualifier-enable bit and the qualifier input, and the expected halt is computed from those bits.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;
  localparam int REG_W       = 32;
  localparam int B_HALT      = 0;
  localparam int B_LD        = 1;
  localparam int B_MODE      = 2;
  localparam int B_STEP      = 4;
  localparam int B_SWBP      = 5;
  localparam int B_HWBP      = 6;
  localparam int B_STEP_TYPE = 7;
  localparam int B_TRBP      = 8;
  localparam int B_QUAL      = 9;
  localparam int B_RUN_EN    = 10;
  localparam int B_HALT_EN   = 11;
  localparam int B_RST       = 25;
  localparam int B_CANCEL    = 30;
  localparam logic [REG_W-1:0] RESET_VAL = 32'h0000_0200;

  typedef struct packed {
    logic swbp_en;
    logic hwbp_en;
    logic trbp_en;
    logic qual_en;
    logic run_en;
    logic halt_en;
    logic step_en;
  } dbg_en_t;
endpackage

// File: rtl/dbg_runctl_cfg.sv
module dbg_runctl_cfg
  import dbg_runctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:2] wdata_i,
  output logic [REG_W-1:2] cfg_o,
  output dbg_en_t          en_o
);
  logic [REG_W-1:2] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= RESET_VAL[REG_W-1:2];
    end else begin
      cfg_q[B_RST]    <= 1'b0;
      cfg_q[B_CANCEL] <= 1'b0;
      if (wr_en_i) cfg_q <= wdata_i;
    end
  end

  always_comb begin
    en_o.swbp_en = cfg_q[B_SWBP];
    en_o.hwbp_en = cfg_q[B_HWBP];
    en_o.trbp_en = cfg_q[B_TRBP];
    en_o.qual_en = cfg_q[B_QUAL];
    en_o.run_en  = cfg_q[B_RUN_EN];
    en_o.halt_en = cfg_q[B_HALT_EN];
    en_o.step_en = cfg_q[B_STEP];
  end

  assign cfg_o = cfg_q;

  p_rst_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[B_RST] && !(wr_en_i && wdata_i[B_RST])) |=> !cfg_q[B_RST]);
  p_cancel_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[B_CANCEL] && !(wr_en_i && wdata_i[B_CANCEL])) |=> !cfg_q[B_CANCEL]);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_q[B_CANCEL-1:B_RST+1]) && $stable(cfg_q[B_RST-1:2]));
endmodule

// File: rtl/dbg_runctl_qual.sv
module dbg_runctl_qual
  import dbg_runctl_pkg::*;
#(
  parameter int NUM_HWBP = 4
) (
  input  dbg_en_t             en_i,
  input  logic                halted_i,
  input  logic                swbp_evt_i,
  input  logic [NUM_HWBP-1:0] hwbp_evt_i,
  input  logic [NUM_HWBP-1:0] hwbp_loc_en_i,
  input  logic                trbp_evt_i,
  input  logic                ext_halt_i,
  input  logic                ext_run_i,
  input  logic                ext_dbg_en_i,
  input  logic                retire_i,
  output logic                halt_set_o,
  output logic                run_req_o,
  output logic                swbp_nop_o
);
  logic [NUM_HWBP-1:0] hw_hit;
  logic allowed, step_done, any_src;

  for (genvar i = 0; i < NUM_HWBP; i++) begin : g_hwbp
    assign hw_hit[i] = hwbp_evt_i[i] & hwbp_loc_en_i[i];
  end

  // qualifier is consulted only when its enable field is set
  assign allowed   = !en_i.qual_en || ext_dbg_en_i;
  assign step_done = en_i.step_en && !halted_i && retire_i;
  assign any_src   = (swbp_evt_i && en_i.swbp_en) ||
                     ((|hw_hit) && en_i.hwbp_en) ||
                     (trbp_evt_i && en_i.trbp_en) ||
                     (ext_halt_i && en_i.halt_en) ||
                     step_done;
  assign halt_set_o = allowed && any_src;
  assign run_req_o  = ext_run_i && en_i.run_en;
  assign swbp_nop_o = !en_i.swbp_en;
endmodule

// File: rtl/dbg_runctl_halt.sv
module dbg_runctl_halt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic run_i,
  input  logic wr_i,
  input  logic ld_i,
  input  logic val_i,
  output logic halt_o
);
  logic halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           halt_q <= 1'b0;
    else if (set_i)        halt_q <= 1'b1;
    else if (wr_i && ld_i) halt_q <= val_i;
    else if (run_i)        halt_q <= 1'b0;
  end

  assign halt_o = halt_q;

  p_evt_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> halt_q);
  p_ld_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !ld_i && !set_i && !run_i) |=> $stable(halt_q));
  p_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !set_i && !(wr_i && ld_i)) |=> !halt_q);
endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
  import dbg_runctl_pkg::*;
#(
  parameter int NUM_HWBP = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic                swbp_evt_i,
  input  logic [NUM_HWBP-1:0] hwbp_evt_i,
  input  logic [NUM_HWBP-1:0] hwbp_loc_en_i,
  input  logic                trbp_evt_i,
  input  logic                ext_halt_i,
  input  logic                ext_run_i,
  input  logic                ext_dbg_en_i,
  input  logic                retire_i,
  output logic                halt_req_o,
  output logic                step_en_o,
  output logic                step_type_o,
  output logic [1:0]          exec_mode_o,
  output logic                reset_req_o,
  output logic                cancel_req_o,
  output logic                swbp_nop_o
);
  logic [REG_W-1:2] cfg;
  dbg_en_t          en;
  logic             halt, halt_set, run_req;

  dbg_runctl_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i[REG_W-1:2]),
    .cfg_o   (cfg),
    .en_o    (en)
  );

  dbg_runctl_qual #(.NUM_HWBP(NUM_HWBP)) u_qual (
    .en_i          (en),
    .halted_i      (halt),
    .swbp_evt_i    (swbp_evt_i),
    .hwbp_evt_i    (hwbp_evt_i),
    .hwbp_loc_en_i (hwbp_loc_en_i),
    .trbp_evt_i    (trbp_evt_i),
    .ext_halt_i    (ext_halt_i),
    .ext_run_i     (ext_run_i),
    .ext_dbg_en_i  (ext_dbg_en_i),
    .retire_i      (retire_i),
    .halt_set_o    (halt_set),
    .run_req_o     (run_req),
    .swbp_nop_o    (swbp_nop_o)
  );

  dbg_runctl_halt u_halt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (halt_set),
    .run_i  (run_req),
    .wr_i   (wr_en_i),
    .ld_i   (wdata_i[B_LD]),
    .val_i  (wdata_i[B_HALT]),
    .halt_o (halt)
  );

  assign rdata_o      = {cfg, 1'b0, halt};
  assign halt_req_o   = halt;
  assign step_en_o    = cfg[B_STEP];
  assign step_type_o  = cfg[B_STEP_TYPE];
  assign exec_mode_o  = cfg[B_MODE+1:B_MODE];
  assign reset_req_o  = cfg[B_RST];
  assign cancel_req_o = cfg[B_CANCEL];

  p_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg[B_QUAL] && !ext_dbg_en_i && !halt_req_o &&
     !(wr_en_i && wdata_i[B_LD] && wdata_i[B_HALT])) |=> !halt_req_o);
  p_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_o && !halt_req_o && retire_i && (!cfg[B_QUAL] || ext_dbg_en_i)) |=> halt_req_o);
  p_halt_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_halt_i && ext_run_i && cfg[B_HALT_EN] && cfg[B_RUN_EN] &&
     (!cfg[B_QUAL] || ext_dbg_en_i)) |=> halt_req_o);
endmodule

// File: tb/dbg_runctl_bench.sv
module dbg_runctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NHW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic swbp_evt_i = 1'b0, trbp_evt_i = 1'b0, ext_halt_i = 1'b0, ext_run_i = 1'b0;
  logic ext_dbg_en_i = 1'b0, retire_i = 1'b0;
  logic [NHW-1:0] hwbp_evt_i = '0, hwbp_loc_en_i = '0;
  logic halt_req_o, step_en_o, step_type_o, reset_req_o, cancel_req_o, swbp_nop_o;
  logic [1:0] exec_mode_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dbg_runctl #(.NUM_HWBP(NHW)) u_dbg_runctl (.*);

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [31:0] v);
    wdata_i = v; wr_en_i = 1'b1; tick(); wr_en_i = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) tick();
    rst_ni = 1'b1; tick();
    // R1 reset state
    chk("R1 rdata", rdata_o, 32'h0000_0200);
    chk("R1 halt", {31'd0, halt_req_o}, 0);
    chk("R1 nop", {31'd0, swbp_nop_o}, 1);
    chk("R1 pulses", {30'd0, reset_req_o, cancel_req_o}, 0);

    // R2 load-enable gate
    wr(32'h0000_0001); chk("R2 no-ld", {31'd0, halt_req_o}, 0);
    wr(32'h0000_0003); chk("R2 ld set", {31'd0, halt_req_o}, 1);
    chk("R2 ld reads 0", rdata_o, 32'h0000_0001);
    wr(32'h0000_0000); chk("R2 hold", {31'd0, halt_req_o}, 1);
    wr(32'h0000_0002); chk("R2 ld clear", {31'd0, halt_req_o}, 0);

    // R3..R7 sweep: enables x qualifier x source
    for (int m = 0; m < 16; m++) begin
      for (int q = 0; q < 4; q++) begin
        for (int k = 0; k < 5; k++) begin
          logic sw, hw, tr, he, q9, dbg, exp_h;
          int idx;
          sw = m[0]; hw = m[1]; tr = m[2]; he = m[3];
          q9 = q[0]; dbg = q[1]; idx = m % NHW;
          wr((32'(sw) << 5) | (32'(hw) << 6) | (32'(tr) << 8) |
             (32'(q9) << 9) | (32'(he) << 11) | 32'h2);
          ext_dbg_en_i = dbg;
          case (k)
            0: begin swbp_evt_i = 1'b1; exp_h = sw; end
            1: begin hwbp_evt_i[idx] = 1'b1; hwbp_loc_en_i[idx] = 1'b1; exp_h = hw; end
            2: begin hwbp_evt_i[idx] = 1'b1; hwbp_loc_en_i = ~(4'b1 << idx); exp_h = 1'b0; end
            3: begin trbp_evt_i = 1'b1; exp_h = tr; end
            default: begin ext_halt_i = 1'b1; exp_h = he; end
          endcase
          exp_h = exp_h & (!q9 | dbg);
          tick();
          swbp_evt_i = 0; trbp_evt_i = 0; ext_halt_i = 0; hwbp_evt_i = '0; hwbp_loc_en_i = '0;
          ext_dbg_en_i = 0;
          case (k)
            0: chk("R3/R7 swbp halt", {31'd0, halt_req_o}, {31'd0, exp_h});
            1, 2: chk("R4/R7 hwbp halt", {31'd0, halt_req_o}, {31'd0, exp_h});
            3: chk("R5/R7 trace halt", {31'd0, halt_req_o}, {31'd0, exp_h});
            default: chk("R6/R7 ext halt", {31'd0, halt_req_o}, {31'd0, exp_h});
          endcase
          chk("R3 nop flag", {31'd0, swbp_nop_o}, {31'd0, !sw});
          chk("R12 rdata bit0", {31'd0, rdata_o[0]}, {31'd0, exp_h});
        end
      end
    end

    // R6 collisions and run gating
    wr(32'h0000_0C02);
    ext_halt_i = 1; ext_run_i = 1; tick(); ext_halt_i = 0; ext_run_i = 0;
    chk("R6 halt wins", {31'd0, halt_req_o}, 1);
    ext_run_i = 1; tick(); ext_run_i = 0;
    chk("R6 run", {31'd0, halt_req_o}, 0);
    ext_halt_i = 1; tick(); ext_halt_i = 0;
    wr(32'h0000_0800);
    ext_run_i = 1; tick(); ext_run_i = 0;
    chk("R6 run disabled", {31'd0, halt_req_o}, 1);

    // R8 event beats clearing write
    wr(32'h0000_0022);
    swbp_evt_i = 1; wr(32'h0000_0022); swbp_evt_i = 0;
    chk("R8 running", {31'd0, halt_req_o}, 1);
    swbp_evt_i = 1; wr(32'h0000_0022); swbp_evt_i = 0;
    chk("R8 halted", {31'd0, halt_req_o}, 1);
    wr(32'h0000_0022); chk("R8 control", {31'd0, halt_req_o}, 0);

    // R9 pulses
    wr(32'h0200_0000);
    chk("R9 rst pulse", {30'd0, reset_req_o, cancel_req_o}, 32'h2);
    chk("R9 rst read", {31'd0, rdata_o[25]}, 1);
    tick();
    chk("R9 rst clear", {30'd0, reset_req_o, cancel_req_o}, 0);
    chk("R9 rst read clr", {31'd0, rdata_o[25]}, 0);
    wr(32'h4000_0000);
    chk("R9 cancel pulse", {30'd0, reset_req_o, cancel_req_o}, 32'h1);
    tick();
    chk("R9 cancel clear", {30'd0, reset_req_o, cancel_req_o}, 0);
    chk("R9 cancel read clr", {31'd0, rdata_o[30]}, 0);

    // R10 single step
    wr(32'h0000_0012);
    tick(); chk("R10 no retire", {31'd0, halt_req_o}, 0);
    retire_i = 1; tick(); retire_i = 0;
    chk("R10 step halt", {31'd0, halt_req_o}, 1);
    chk("R10 bit0", {31'd0, rdata_o[0]}, 1);
    wr(32'h0000_0212);
    retire_i = 1; tick(); retire_i = 0;
    chk("R10/R7 gated step", {31'd0, halt_req_o}, 0);
    ext_dbg_en_i = 1; retire_i = 1; tick(); retire_i = 0; ext_dbg_en_i = 0;
    chk("R10/R7 qualified step", {31'd0, halt_req_o}, 1);

    // R11 walking-one store/readback
    wr(32'h0000_0002);
    for (int i = 2; i < 32; i++) begin
      if (i != 25 && i != 30) begin
        wr(32'h1 << i);
        chk("R11 readback", rdata_o, 32'h1 << i);
        chk("R11 mode", {30'd0, exec_mode_o}, (32'h1 << i) >> 2 & 32'h3);
        chk("R11 step", {30'd0, step_en_o, step_type_o},
            {30'd0, i == 4, i == 7});
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule